// File: doc/BRIEF.md
# In-Order Instruction Dispatch Queue

This block sits between an instruction fetch stage and the execution units. It buffers up to four fetched instructions in arrival order and hands them on one at a time from the oldest slot. An instruction leaves only in a cycle where the downstream completion queue reports a free slot. Every instruction that leaves therefore takes one completion entry, and branches of every kind, conditional or not, are held by the same gate as any other instruction. This keeps program order intact for retirement.

Each fetched word comes with a two-bit class code. The queue turns that code into an is-branch flag, which travels with the instruction to the dispatch port. The fetch side is throttled with a ready signal that drops when all slots are occupied. A flush input discards every held instruction in a single cycle. The dispatch strobe also serves as the completion-queue allocate pulse.

Top module: `instr_dispatch_queue`

## Requirements
- R1: After synchronous reset the queue is empty: `fetch_ready` is 1 and `disp_valid` is 0 even when `cq_free` is 1.
- R2: A fetched word is stored when `fetch_valid` and `fetch_ready` are both 1 at a rising edge with `flush` low. At most one word enters per cycle.
- R3: With four words held, `fetch_ready` is 0 and a word offered with `fetch_valid` is not stored. This holds even in a cycle that also dispatches.
- R4: `disp_valid` is 1 exactly when the queue holds at least one word, `cq_free` is 1 and `flush` is 0. At most one word leaves per cycle, and always the oldest.
- R5: While `cq_free` is 0, nothing is dispatched and the oldest word stays at the head. This applies to branch words (class 2 or 3) as well.
- R6: A store and a dispatch in the same cycle leave the number of held words unchanged.
- R7: A cycle with `flush` high empties the queue. That cycle dispatches nothing, and a word fetched in that cycle is dropped.
- R8: `disp_branch` is 1 when the dispatched word was fetched with `fetch_kind` equal to 2 (conditional branch) or 3 (unconditional branch), and 0 for class 0 (arithmetic) or 1 (memory).
- R9: `disp_instr` equals the fetched word unchanged. A word stored in cycle n can be dispatched no earlier than cycle n+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Fetch stage offers a word |
| fetch_ready | output | 1 | Queue can take a word this cycle |
| fetch_instr | input | IW | Fetched instruction word |
| fetch_kind | input | 2 | Class code: 0 arith, 1 memory, 2 cond branch, 3 uncond branch |
| cq_free | input | 1 | Completion queue has a free slot this cycle |
| flush | input | 1 | Discard all held words |
| disp_valid | output | 1 | Head word dispatched and completion slot allocated |
| disp_instr | output | IW | Dispatched instruction word |
| disp_branch | output | 1 | Dispatched word is a branch |

## Verification
The hardest condition to reach is a full queue that dispatches and receives an offered fetch in the same cycle. The full-queue ready must stay low there, so the offered word must be dropped, and the occupancy must not drift. The stimulus fills the queue with the completion gate held closed. It then opens the gate while fetch keeps offering words. A long phase follows in which `cq_free`, `fetch_valid` and the class code toggle at random, with occasional flushes, and every cycle is compared with a FIFO model in the bench.

// File: rtl/dq_pkg.sv
package dq_pkg;

  typedef enum logic [1:0] {
    KIND_ARITH  = 2'd0,
    KIND_MEM    = 2'd1,
    KIND_BCOND  = 2'd2,
    KIND_BUNCON = 2'd3
  } instr_kind_e;

  function automatic logic kind_is_branch(input logic [1:0] kind);
    return (kind == KIND_BCOND) || (kind == KIND_BUNCON);
  endfunction

endpackage

// File: rtl/dq_store.sv
module dq_store #(
  parameter int DEPTH = 4,
  parameter int EW    = 33,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [EW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [EW-1:0] rdata
);

  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/dq_ctrl.sv
module dq_ctrl #(
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fetch_valid,
  input  logic          cq_free,
  input  logic          flush,
  output logic          fetch_ready,
  output logic          push,
  output logic          pop,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [CW-1:0] count;

  assign fetch_ready = (count != FULL_CNT);
  assign push        = fetch_valid && fetch_ready && !flush;
  assign pop         = (count != '0) && cq_free && !flush;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R3
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (count == FULL_CNT && !pop && !flush) |=> (count == FULL_CNT));

  // R4
  pop_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !push) |=> (count == $past(count) - 1'b1));

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (count != '0 && !cq_free && !flush) |=> (rd_ptr == $past(rd_ptr)));

  // R6
  occ_same_chk: assert property (@(posedge clk) disable iff (rst)
    (push && pop) |=> (count == $past(count)));

  // R7
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count == '0 && fetch_ready));

endmodule

// File: rtl/instr_dispatch_queue.sv
module instr_dispatch_queue #(
  parameter int DEPTH = 4,
  parameter int IW    = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int EW   = IW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fetch_valid,
  output logic          fetch_ready,
  input  logic [IW-1:0] fetch_instr,
  input  logic [1:0]    fetch_kind,
  input  logic          cq_free,
  input  logic          flush,
  output logic          disp_valid,
  output logic [IW-1:0] disp_instr,
  output logic          disp_branch
);

  logic          push, pop;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [EW-1:0] wdata, rdata;

  dq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .fetch_valid (fetch_valid),
    .cq_free     (cq_free),
    .flush       (flush),
    .fetch_ready (fetch_ready),
    .push        (push),
    .pop         (pop),
    .wr_ptr      (wr_ptr),
    .rd_ptr      (rd_ptr)
  );

  assign wdata = {dq_pkg::kind_is_branch(fetch_kind), fetch_instr};

  dq_store #(.DEPTH(DEPTH), .EW(EW)) u_store (
    .clk   (clk),
    .we    (push),
    .waddr (wr_ptr),
    .wdata (wdata),
    .raddr (rd_ptr),
    .rdata (rdata)
  );

  assign disp_valid  = pop;
  assign disp_instr  = rdata[IW-1:0];
  assign disp_branch = rdata[IW];

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (fetch_ready && !disp_valid));

  // R7
  flush_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    flush |-> !disp_valid);

endmodule

// File: tb/instr_dispatch_queue_tb.sv
module instr_dispatch_queue_tb;

  localparam int IW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          fetch_valid;
  logic          fetch_ready;
  logic [IW-1:0] fetch_instr;
  logic [1:0]    fetch_kind;
  logic          cq_free;
  logic          flush;
  logic          disp_valid;
  logic [IW-1:0] disp_instr;
  logic          disp_branch;

  int checks = 0;
  int errors = 0;

  logic [IW:0] mq[$];

  always #5 clk = ~clk;

  instr_dispatch_queue #(.DEPTH(4), .IW(IW)) u_dut (
    .clk         (clk),
    .rst         (rst),
    .fetch_valid (fetch_valid),
    .fetch_ready (fetch_ready),
    .fetch_instr (fetch_instr),
    .fetch_kind  (fetch_kind),
    .cq_free     (cq_free),
    .flush       (flush),
    .disp_valid  (disp_valid),
    .disp_instr  (disp_instr),
    .disp_branch (disp_branch)
  );

  task automatic check(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one cycle, compare against the FIFO model, then advance the model.
  task automatic step(input logic fv, input logic [IW-1:0] ins, input logic [1:0] kd,
                      input logic cq, input logic fl, input string tag);
    logic exp_rdy, exp_dv;
    @(negedge clk);
    fetch_valid = fv; fetch_instr = ins; fetch_kind = kd; cq_free = cq; flush = fl;
    #4;
    exp_rdy = (mq.size() < 4);
    exp_dv  = (mq.size() > 0) && cq && !fl;
    check(fetch_ready == exp_rdy, {tag, " R3 fetch_ready"}, 64'(fetch_ready), 64'(exp_rdy));
    check(disp_valid == exp_dv, {tag, " R4 disp_valid"}, 64'(disp_valid), 64'(exp_dv));
    if (exp_dv && disp_valid) begin
      check(disp_instr == mq[0][IW-1:0], {tag, " R9 disp_instr"},
            64'(disp_instr), 64'(mq[0][IW-1:0]));
      check(disp_branch == mq[0][IW], {tag, " R8 disp_branch"},
            64'(disp_branch), 64'(mq[0][IW]));
    end
    if (fl) mq.delete();
    else begin
      if (exp_dv) void'(mq.pop_front());
      if (fv && exp_rdy) mq.push_back({kd[1], ins});
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; fetch_valid = 1'b0; fetch_instr = '0; fetch_kind = '0;
    cq_free = 1'b1; flush = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: empty after reset, no dispatch although completion slot is free
    step(1'b0, '0, 2'd0, 1'b1, 1'b0, "R1 reset");

    // R9: a word stored this cycle is not dispatched in the same cycle
    step(1'b1, 32'hA0000001, 2'd0, 1'b1, 1'b0, "R9 enter");
    step(1'b0, '0, 2'd0, 1'b1, 1'b0, "R9 leave");

    // R5/R3: fill with gate closed, branches at head, then offer a fifth word
    step(1'b1, 32'hB0000001, 2'd3, 1'b0, 1'b0, "R5 fill");
    step(1'b1, 32'hB0000002, 2'd2, 1'b0, 1'b0, "R5 fill");
    step(1'b1, 32'hB0000003, 2'd1, 1'b0, 1'b0, "R5 fill");
    step(1'b1, 32'hB0000004, 2'd0, 1'b0, 1'b0, "R5 fill");
    for (int i = 0; i < 3; i++) step(1'b1, 32'hDEAD0000 + i, 2'd3, 1'b0, 1'b0, "R3 full");
    // R3/R6: full queue dispatches while fetch is offered; offered word dropped
    step(1'b1, 32'hDEADBEEF, 2'd1, 1'b1, 1'b0, "R3 full+pop");
    // R6: simultaneous store and dispatch keep occupancy at three
    for (int i = 0; i < 4; i++) step(1'b1, 32'hC0000000 + i, 2'(i), 1'b1, 1'b0, "R6 steady");
    // R7: flush with fetch offered and gate open
    step(1'b1, 32'hF1F1F1F1, 2'd2, 1'b1, 1'b1, "R7 flush");
    step(1'b0, '0, 2'd0, 1'b1, 1'b0, "R7 after");
    // R8: every class code through the queue
    for (int k = 0; k < 4; k++) step(1'b1, 32'h80000000 + k, 2'(k), 1'b1, 1'b0, "R8 kind");
    step(1'b0, '0, 2'd0, 1'b1, 1'b0, "R8 drain");

    // R2/R4: random fetch, random completion gate, rare flushes
    for (int n = 0; n < 4000; n++)
      step(1'($urandom_range(0, 3) != 0), $urandom(), 2'($urandom_range(0, 3)),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 63) == 0), "R2 random");
    for (int n = 0; n < 6; n++) step(1'b0, '0, 2'd0, 1'b1, 1'b0, "R4 drain");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule